// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-visible register set of one DMA channel that serves a
single peripheral, such as a disk or SCSI controller. A 32-bit slave bus reaches
four word registers. Only full-word accesses exist, and only two address bits
select a register. The block turns the peripheral's level interrupt into a
pending flag and gates that flag onto a system interrupt line. It gives the
peripheral a one-cycle reset pulse and a DMA-enable level. It also moves the
transfer address forward as the peripheral reports moved bytes.

Software programs a base address, a count and an auxiliary address, then writes
the control word to set the direction and the enable. The peripheral reports each
burst through a length strobe, and software later reads back the address to see
how far the transfer got. The engine that moves data on the memory side, and any
address translation, sit outside this block.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the control word (index 0) reads 0xA0000000 and the address (index 1), count (index 2) and auxiliary (index 3) words read 0. The irq_o, per_rst_o, dma_en_o and to_mem_o outputs are low.
- R2: bus_addr[3:2] selects the register index and all other address bits are ignored. Read data appears on bus_rdata on the cycle after bus_re is sampled.
- R3: A control-word write keeps the old value of bits 31:25 and 2:0 and takes every other bit from bus_wdata.
- R4: Control bit 6 (drain) never reads back as 1 after a write unless bit 7 was also written as 1 in that same write.
- R5: A control-word write with bit 7 set drives per_rst_o high for exactly the cycle after the write. per_rst_o stays low otherwise.
- R6: dma_en_o follows control bit 9. It rises on a write that sets the bit while it was clear, and falls on a write that clears it while it was set, one cycle after the write.
- R7: A rising per_irq_i sets pending bit 0 of the control word. irq_o goes high one cycle later only if interrupt-enable bit 4 is set. irq_o is never high unless pending and enable are both set.
- R8: A falling per_irq_i clears the pending bit and drops irq_o.
- R9: A control-word write with bit 4 set raises irq_o if pending is set. A control-word write with bit 4 clear lowers irq_o.
- R10: Any write to the address word sets control bit 26 (loaded). Control-word writes cannot clear it.
- R11: Each cycle with xfer_valid_i high adds xfer_len_i to the address word, modulo 2^32. A bus write to the address word in the same cycle takes precedence.
- R12: Control bit 8 (direction, 1 = write to memory) is read/write and drives to_mem_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Full-word write strobe |
| bus_re | input | 1 | Full-word read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| per_irq_i | input | 1 | Level interrupt from the peripheral |
| per_rst_o | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_o | output | 1 | DMA enable level |
| to_mem_o | output | 1 | Transfer direction, 1 = into memory |
| irq_o | output | 1 | System interrupt request |
| xfer_valid_i | input | 1 | Peripheral moved xfer_len_i bytes this cycle |
| xfer_len_i | input | LEN_W | Byte count of the reported transfer |

## Verification
The control word is swept with repeated-nibble patterns in a rising and then a falling order. This separates writable bits from read-only bits, makes every combination of the drain and reset bits appear, and toggles the enable bit both ways. The interrupt path is driven through its ordered cases: an edge while enabled, an edge while disabled followed by a late enable, and an enable cleared while pending. These show whether the output follows the stored enable or the written data. The address counter is stepped by every length from 0 to 255, starting near the top of its range so that it wraps, and one strobe collides with a bus write. A read at each of the 64 word offsets of an 8-bit address shows that only two bits decode.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_TOMEM  = 8;
  localparam int unsigned B_EN     = 9;
  localparam int unsigned B_LOADED = 26;

  localparam logic [WORD_W-1:0] RO_MASK   = 32'hFE00_0007;
  localparam logic [WORD_W-1:0] CTL_RESET = 32'hA000_0000;

  typedef enum logic [1:0] {
    IDX_CTL  = 2'd0,
    IDX_ADDR = 2'd1,
    IDX_CNT  = 2'd2,
    IDX_AUX  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              set_loaded,
  output logic [WORD_W-1:0] ctl_q,
  output logic              prst_o,
  output logic              en_o,
  output logic              tomem_o
);
  logic [WORD_W-1:0] wmod;

  always_comb begin
    wmod = wdata;
    if (!wdata[B_PRST]) wmod[B_DRAIN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_RESET;
      prst_o  <= 1'b0;
      en_o    <= 1'b0;
      tomem_o <= 1'b0;
    end else begin
      prst_o <= ctl_we & wdata[B_PRST];
      if (ctl_we) begin
        ctl_q   <= (ctl_q & RO_MASK) | (wmod & ~RO_MASK);
        tomem_o <= wdata[B_TOMEM];
        if (wdata[B_EN] && !ctl_q[B_EN]) en_o <= 1'b1;
        else if (!wdata[B_EN] && ctl_q[B_EN]) en_o <= 1'b0;
      end
      if (set_loaded) ctl_q[B_LOADED] <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic per_irq,
  input  logic ctl_we,
  input  logic wr_ien,
  input  logic ien_q,
  output logic pend_o,
  output logic irq_o
);
  logic irq_d, rise, fall, pend_n, irq_n;

  assign rise = per_irq & ~irq_d;
  assign fall = ~per_irq & irq_d;

  always_comb begin
    pend_n = pend_o;
    irq_n  = irq_o;
    if (rise) begin
      pend_n = 1'b1;
      if (ien_q) irq_n = 1'b1;
    end else if (fall && pend_o) begin
      pend_n = 1'b0;
      if (ien_q) irq_n = 1'b0;
    end
    if (ctl_we) begin
      if (wr_ien) begin
        if (pend_n) irq_n = 1'b1;
      end else if (pend_n || ien_q) begin
        irq_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d  <= 1'b0;
      pend_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_d  <= per_irq;
      pend_o <= pend_n;
      irq_o  <= irq_n;
    end
  end
endmodule

// File: rtl/dma_chan_words.sv
module dma_chan_words
  import dma_chan_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              xfer_valid,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic [WORD_W-1:0] word_q [1:3],
  output logic              addr_wr
);
  localparam int unsigned PAD_W = WORD_W - LEN_W;

  assign addr_wr = we && (idx == IDX_ADDR);

  for (genvar k = 1; k <= 3; k++) begin : g_word
    if (k == 1) begin : g_counting
      always_ff @(posedge clk) begin
        if (rst)              word_q[k] <= '0;
        else if (addr_wr)     word_q[k] <= wdata;
        else if (xfer_valid)  word_q[k] <= word_q[k] + {{PAD_W{1'b0}}, xfer_len};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                         word_q[k] <= '0;
        else if (we && idx == 2'(k))     word_q[k] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              per_irq_i,
  output logic              per_rst_o,
  output logic              dma_en_o,
  output logic              to_mem_o,
  output logic              irq_o,
  input  logic              xfer_valid_i,
  input  logic [LEN_W-1:0]  xfer_len_i
);
  logic [1:0]        idx;
  logic              ctl_we, addr_wr, pend_w;
  logic [WORD_W-1:0] csr_w;
  logic [WORD_W-1:0] words [1:3];
  logic [WORD_W-1:0] rd_mux;

  assign idx    = bus_addr[3:2];
  assign ctl_we = bus_we && (idx == IDX_CTL);

  dma_chan_ctl u_ctl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .wdata(bus_wdata),
    .set_loaded(addr_wr), .ctl_q(csr_w), .prst_o(per_rst_o),
    .en_o(dma_en_o), .tomem_o(to_mem_o)
  );

  dma_chan_irq u_irq (
    .clk(clk), .rst(rst), .per_irq(per_irq_i), .ctl_we(ctl_we),
    .wr_ien(bus_wdata[B_IEN]), .ien_q(csr_w[B_IEN]),
    .pend_o(pend_w), .irq_o(irq_o)
  );

  dma_chan_words #(.LEN_W(LEN_W)) u_words (
    .clk(clk), .rst(rst), .we(bus_we), .idx(idx), .wdata(bus_wdata),
    .xfer_valid(xfer_valid_i), .xfer_len(xfer_len_i),
    .word_q(words), .addr_wr(addr_wr)
  );

  always_comb begin
    if (idx == IDX_CTL) rd_mux = {csr_w[WORD_W-1:1], pend_w};
    else                rd_mux = words[idx];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              per_irq_i,
  input logic              per_rst_o,
  input logic              dma_en_o,
  input logic              irq_o,
  input logic              xfer_valid_i,
  input logic [LEN_W-1:0]  xfer_len_i,
  input logic              pend,
  input logic [31:0]       ctl,
  input logic [31:0]       addr_word
);
  logic ctl_wr, adr_wr;
  assign ctl_wr = bus_we && (bus_addr[3:2] == 2'd0);
  assign adr_wr = bus_we && (bus_addr[3:2] == 2'd1);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend && ctl[4])); // R7
  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    (per_irq_i && !$past(per_irq_i)) |=> pend); // R7
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (rst)
    (!per_irq_i && $past(per_irq_i)) |=> (!pend && !irq_o)); // R8
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    per_rst_o |-> $past(ctl_wr && bus_wdata[7])); // R5
  AST_EN_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_en_o) |-> $past(ctl_wr && bus_wdata[9])); // R6
  AST_LOADED: assert property (@(posedge clk) disable iff (rst)
    adr_wr |=> ctl[26]); // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_i && !adr_wr) |=>
      (addr_word == $past(addr_word) + 32'($past(xfer_len_i)))); // R11
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .per_irq_i(per_irq_i), .per_rst_o(per_rst_o),
  .dma_en_o(dma_en_o), .irq_o(irq_o), .xfer_valid_i(xfer_valid_i),
  .xfer_len_i(xfer_len_i), .pend(pend_w), .ctl(csr_w),
  .addr_word(words[1])
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 8;
  localparam logic [31:0] ROM = 32'hFE00_0007;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic per_irq_i = 1'b0, per_rst_o, dma_en_o, to_mem_o, irq_o;
  logic xfer_valid_i = 1'b0;
  logic [LEN_W-1:0] xfer_len_i = '0;

  int checks = 0, failures = 0;
  logic [31:0] mdl [0:3];
  logic [31:0] rd;

  always #5 clk = ~clk;

  dma_chan_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdw(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl_next(logic [31:0] old, logic [31:0] v);
    logic [31:0] w = v;
    if (!v[7]) w[6] = 1'b0;
    return (old & ROM) | (w & ~ROM);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mdl[0] = 32'hA000_0000; mdl[1] = 0; mdl[2] = 0; mdl[3] = 0;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rdw(ADDR_W'(i * 4), rd);
      chk("R1 reset value", rd, mdl[i]);
    end
    chk("R1 outputs low", {28'd0, irq_o, per_rst_o, dma_en_o, to_mem_o}, 32'd0);

    // R3 R4 R5 R6 R12 control sweep
    for (int j = 0; j < 32; j++) begin
      int n = (j < 16) ? j : 31 - j;
      logic [31:0] v = 32'h1111_1111 * n;
      logic prev_en = mdl[0][9];
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = v; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      mdl[0] = ctl_next(mdl[0], v);
      chk("R5 reset pulse high", {31'd0, per_rst_o}, {31'd0, v[7]});
      chk("R6 enable level", {31'd0, dma_en_o}, {31'd0, v[9]});
      chk("R12 direction", {31'd0, to_mem_o}, {31'd0, v[8]});
      chk("R9 no pending no irq", {31'd0, irq_o}, 32'd0);
      @(negedge clk);
      chk("R5 pulse one cycle", {31'd0, per_rst_o}, 32'd0);
      if (prev_en != v[9]) chk("R6 enable edge held", {31'd0, dma_en_o}, {31'd0, v[9]});
      rdw(8'h00, rd);
      chk("R3 masked write", rd, mdl[0]);
      if (!v[7]) chk("R4 drain clears", {31'd0, rd[6]}, 32'd0);
    end

    // interrupt ordering: R7 R8 R9
    wr(8'h00, 32'h10); mdl[0] = ctl_next(mdl[0], 32'h10);
    @(negedge clk) per_irq_i = 1'b1;
    @(negedge clk);
    chk("R7 irq raised with enable", {31'd0, irq_o}, 32'd1);
    rdw(8'h00, rd);
    chk("R7 pending set", {31'd0, rd[0]}, 32'd1);
    @(negedge clk) per_irq_i = 1'b0;
    @(negedge clk);
    chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);
    rdw(8'h00, rd);
    chk("R8 pending cleared", {31'd0, rd[0]}, 32'd0);
    wr(8'h00, 32'h0);
    @(negedge clk) per_irq_i = 1'b1;
    @(negedge clk);
    chk("R7 no irq without enable", {31'd0, irq_o}, 32'd0);
    rdw(8'h00, rd);
    chk("R7 pending without enable", {31'd0, rd[0]}, 32'd1);
    wr(8'h00, 32'h10);
    chk("R9 late enable raises", {31'd0, irq_o}, 32'd1);
    wr(8'h00, 32'h0);
    chk("R9 clearing enable lowers", {31'd0, irq_o}, 32'd0);
    @(negedge clk) per_irq_i = 1'b0;
    @(negedge clk);
    rdw(8'h00, rd);
    chk("R8 pending cleared while disabled", {31'd0, rd[0]}, 32'd0);
    mdl[0] = ctl_next(mdl[0], 32'h0);

    // R10 loaded flag and R11 address stepping with wrap
    wr(8'h04, 32'hFFFF_FF00); mdl[1] = 32'hFFFF_FF00;
    rdw(8'h00, rd);
    chk("R10 loaded set", {31'd0, rd[26]}, 32'd1);
    wr(8'h00, 32'h0);
    rdw(8'h00, rd);
    chk("R10 loaded kept", {31'd0, rd[26]}, 32'd1);
    mdl[0] = rd;
    for (int len = 0; len < 256; len++) begin
      @(negedge clk);
      xfer_valid_i = 1'b1; xfer_len_i = LEN_W'(len);
      mdl[1] = mdl[1] + 32'(len);
      if (len % 64 == 63) begin
        @(negedge clk) xfer_valid_i = 1'b0;
        rdw(8'h04, rd);
        chk("R11 address advance", rd, mdl[1]);
      end
    end
    @(negedge clk);
    xfer_valid_i = 1'b1; xfer_len_i = 8'd9;
    bus_addr = 8'h04; bus_wdata = 32'h0000_1000; bus_we = 1'b1;
    @(negedge clk);
    xfer_valid_i = 1'b0; bus_we = 1'b0;
    mdl[1] = 32'h0000_1000;
    rdw(8'h04, rd);
    chk("R11 bus write wins", rd, mdl[1]);

    // R2 decode sweep over every word offset
    wr(8'hF8, 32'h1234_5678); mdl[2] = 32'h1234_5678;
    wr(8'h3C, 32'hC0DE_F00D); mdl[3] = 32'hC0DE_F00D;
    for (int a = 0; a < 256; a += 4) begin
      rdw(ADDR_W'(a), rd);
      chk("R2 decode", rd, mdl[(a >> 2) & 3]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule